// File: doc/BRIEF.md
# Windowed Event Count Flag

This block watches one raw event line and raises a sticky interrupt flag once a programmable number of clean rising edges has arrived inside one time window. The raw line is synchronised into the system clock domain. A level change is accepted only after the line has stayed put for a set number of ticks of a 32.768 kHz time base, which arrives as a one-cycle enable. Only an accepted low-to-high change counts as an event.

A two-bit threshold field picks how many events are needed. The first event of a burst opens a window of 8192 ticks (250 ms at the nominal tick rate). If the window runs out before the count is reached, the count starts again from zero. A run enable stands for "timekeeping clock running". While it is low, no event is accepted and the window does not advance. The flag stays set until software pulses the clear strobe.

The flag is a plain level and the other pins are plain control inputs. No data is streamed, so there is no valid/ready handshake and no back-pressure.

Top module: `evt_burst_flag`

## Requirements
- R1: The threshold field selects the event on which the flag sets: 2'b00 the 1st, 2'b01 the 4th, 2'b10 the 16th and 2'b11 the 32nd qualified event of a window. Fewer events leave the flag clear.
- R2: The first qualified event opens a window of WIN_TICKS ticks (default 8192). If the window expires before the threshold is reached, the count returns to zero and the flag stays clear.
- R3: Once set, the flag stays high until flag_clr is high on a clock edge. It is low from the following cycle.
- R4: If flag_clr and a threshold hit fall on the same clock edge, the flag ends up set.
- R5: A level on evt_raw that lasts fewer than DEB_TICKS ticks produces no event.
- R6: Only a debounced low-to-high change is an event. Falling changes do not count.
- R7: While run_en is low, no event is qualified and the window timer holds its position.
- R8: Any change of thresh_sel clears the event count and closes the window.
- R9: After reset the flag is low and no events are counted.
- R10: With threshold 2'b00, the flag sets on the edge that qualifies the first event, without waiting for any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at the 32.768 kHz tick rate |
| run_en | input | 1 | Timekeeping clock running; gates the debounce and the window timer |
| evt_raw | input | 1 | Raw asynchronous event line |
| thresh_sel | input | 2 | Event-count threshold code |
| flag_clr | input | 1 | Clear strobe for the flag |
| flag | output | 1 | Sticky event interrupt flag |

## Verification
Each threshold code is driven with bursts of clean pulses. The flag is sampled one event short of the target and again at the target. This separates the four codes and shows whether falling edges are being miscounted.

Short glitches and long held levels separate the debounce from plain edge detection. A burst split by a full window expiry, and the same burst split by a long pause with run_en low, separate a window that really expires from one that is frozen. A threshold toggle in the middle of a burst, and a clear held high across a hit, exercise the restart and the clear/set priority.

// File: rtl/evt_burst_pkg.sv
package evt_burst_pkg;

  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {
    THR_1  = 2'b00,
    THR_4  = 2'b01,
    THR_16 = 2'b10,
    THR_32 = 2'b11
  } thr_sel_e;

  function automatic logic [CNT_W-1:0] thr_target(thr_sel_e s);
    case (s)
      THR_1:   thr_target = CNT_W'(1);
      THR_4:   thr_target = CNT_W'(4);
      THR_16:  thr_target = CNT_W'(16);
      default: thr_target = CNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/evt_debounce.sv
module evt_debounce #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_TICKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_en,
  input  logic raw_in,
  output logic evt_q
);
  localparam int unsigned DW = $clog2(DEB_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_r;
  logic                   sync_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_r[0] <= 1'b0;
          else        sync_r[0] <= raw_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_r[i] <= 1'b0;
          else        sync_r[i] <= sync_r[i-1];
      end
    end
  endgenerate

  assign sync_q = sync_r[SYNC_STAGES-1];

  logic          cand;
  logic          lvl;
  logic [DW-1:0] stab_cnt;
  logic          run_tick;
  logic          settled;

  assign run_tick = tick & run_en;
  assign settled  = (sync_q == cand) && (stab_cnt == DW'(DEB_TICKS - 1));
  assign evt_q    = run_tick && settled && cand && !lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand     <= 1'b0;
      lvl      <= 1'b0;
      stab_cnt <= '0;
    end else if (run_tick) begin
      if (sync_q != cand) begin
        cand     <= sync_q;
        stab_cnt <= '0;
      end else if (stab_cnt != DW'(DEB_TICKS - 1)) begin
        stab_cnt <= stab_cnt + DW'(1);
      end else begin
        lvl <= cand;
      end
    end
  end

endmodule

// File: rtl/evt_window_timer.sv
module evt_window_timer #(
  parameter int unsigned WIN_TICKS = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_en,
  input  logic start,
  input  logic stop,
  output logic win_open,
  output logic expire
);
  localparam int unsigned WW = $clog2(WIN_TICKS + 1);

  logic [WW-1:0] age;

  assign expire = win_open && tick && run_en && (age == WW'(WIN_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      age      <= '0;
    end else if (stop) begin
      win_open <= 1'b0;
      age      <= '0;
    end else if (start) begin
      win_open <= 1'b1;
      age      <= '0;
    end else if (expire) begin
      win_open <= 1'b0;
      age      <= '0;
    end else if (win_open && tick && run_en) begin
      age <= age + WW'(1);
    end
  end

endmodule

// File: rtl/evt_burst_count.sv
module evt_burst_count
  import evt_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_q,
  input  logic [1:0]       thresh_sel,
  input  logic             win_expire,
  input  logic             flag_clr,
  output logic             win_start,
  output logic             win_stop,
  output logic             thr_hit,
  output logic [CNT_W-1:0] evt_cnt,
  output logic             flag
);
  logic [1:0]       thr_q;
  logic             thr_chg;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] eff_cnt;
  logic [CNT_W-1:0] nxt_cnt;

  assign thr_chg   = (thresh_sel != thr_q);
  assign target    = thr_target(thr_sel_e'(thresh_sel));
  assign eff_cnt   = win_expire ? '0 : evt_cnt;
  assign nxt_cnt   = eff_cnt + CNT_W'(1);
  assign thr_hit   = evt_q && !thr_chg && (nxt_cnt == target);
  assign win_start = evt_q && !thr_chg && !thr_hit && (eff_cnt == '0);
  assign win_stop  = thr_hit || thr_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= 2'b00;
      evt_cnt <= '0;
    end else begin
      thr_q <= thresh_sel;
      if (thr_chg || thr_hit) evt_cnt <= '0;
      else if (evt_q)         evt_cnt <= nxt_cnt;
      else if (win_expire)    evt_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (thr_hit)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/evt_burst_flag.sv
module evt_burst_flag
  import evt_burst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_TICKS   = 4,
  parameter int unsigned WIN_TICKS   = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run_en,
  input  logic       evt_raw,
  input  logic [1:0] thresh_sel,
  input  logic       flag_clr,
  output logic       flag
);
  logic             evt_q;
  logic             win_start;
  logic             win_stop;
  logic             win_open;
  logic             win_expire;
  logic             thr_hit;
  logic [CNT_W-1:0] evt_cnt;

  evt_debounce #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_TICKS  (DEB_TICKS)
  ) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .run_en(run_en),
    .raw_in(evt_raw),
    .evt_q (evt_q)
  );

  evt_window_timer #(
    .WIN_TICKS(WIN_TICKS)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run_en  (run_en),
    .start   (win_start),
    .stop    (win_stop),
    .win_open(win_open),
    .expire  (win_expire)
  );

  evt_burst_count u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_q     (evt_q),
    .thresh_sel(thresh_sel),
    .win_expire(win_expire),
    .flag_clr  (flag_clr),
    .win_start (win_start),
    .win_stop  (win_stop),
    .thr_hit   (thr_hit),
    .evt_cnt   (evt_cnt),
    .flag      (flag)
  );

endmodule

// File: rtl/evt_burst_flag_chk.sv
module evt_burst_flag_chk
  import evt_burst_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             flag_clr,
  input logic             flag,
  input logic             evt_q,
  input logic             thr_hit,
  input logic             win_open,
  input logic [CNT_W-1:0] evt_cnt
);
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !thr_hit) |=> !flag);

  p_hit_beats_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> flag);

  p_rise_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !$past(flag)) |-> $past(thr_hit));

  p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !evt_q);

  p_window_tracks_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_open == (evt_cnt != '0));

endmodule

bind evt_burst_flag evt_burst_flag_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .flag_clr(flag_clr),
  .flag    (flag),
  .evt_q   (evt_q),
  .thr_hit (thr_hit),
  .win_open(win_open),
  .evt_cnt (evt_cnt)
);

// File: tb/evt_burst_flag_tb_top.sv
`timescale 1ns/1ps
module evt_burst_flag_tb_top;
  localparam int DEB = 4;
  localparam int WIN = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       run_en = 1'b1;
  logic       evt_raw = 1'b0;
  logic [1:0] thresh_sel = 2'b00;
  logic       flag_clr = 1'b0;
  logic       flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  evt_burst_flag dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run_en    (run_en),
    .evt_raw   (evt_raw),
    .thresh_sel(thresh_sel),
    .flag_clr  (flag_clr),
    .flag      (flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] thr);
    @(negedge clk);
    rst_n = 1'b0; evt_raw = 1'b0; flag_clr = 1'b0; run_en = 1'b1; thresh_sel = thr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_evt();
    evt_raw = 1'b1;
    wait_ticks(DEB + 4);
    evt_raw = 1'b0;
    wait_ticks(DEB + 4);
  endtask

  task automatic pulse_n(input int n);
    for (int i = 0; i < n; i++) pulse_evt();
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    chk("R9 flag after reset", flag, 0);
    wait_ticks(20);
    chk("R9 flag idle", flag, 0);
  endtask

  task automatic t_thresholds();
    int need [4] = '{1, 4, 16, 32};
    for (int s = 1; s < 4; s++) begin
      do_reset(2'(s));
      pulse_n(need[s] - 1);
      chk($sformatf("R1 code %0d one short", s), flag, 0);
      pulse_evt();
      chk($sformatf("R1 code %0d at target", s), flag, 1);
    end
  endtask

  task automatic t_first_event();
    do_reset(2'b00);
    evt_raw = 1'b1;
    wait_ticks(DEB + 3);
    chk("R10 flag set while event high", flag, 1);
    chk("R1 code 0 sets on 1st", flag, 1);
    evt_raw = 1'b0;
    wait_ticks(DEB + 4);
  endtask

  task automatic t_sticky_clear();
    do_reset(2'b00);
    pulse_evt();
    wait_ticks(50);
    chk("R3 flag held", flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R3 flag cleared", flag, 0);
    wait_ticks(10);
    chk("R3 flag stays clear", flag, 0);
  endtask

  task automatic t_clr_collide();
    int high_cycles = 0;
    do_reset(2'b00);
    flag_clr = 1'b1;
    evt_raw = 1'b1;
    for (int i = 0; i < 2 * (DEB + 6); i++) begin
      @(negedge clk);
      if (flag) high_cycles++;
    end
    flag_clr = 1'b0;
    evt_raw = 1'b0;
    chk("R4 hit wins over clear (cycles high)", high_cycles, 1);
    wait_ticks(DEB + 4);
  endtask

  task automatic t_glitch();
    do_reset(2'b00);
    for (int i = 0; i < 5; i++) begin
      evt_raw = 1'b1;
      wait_ticks(DEB - 2);
      evt_raw = 1'b0;
      wait_ticks(DEB + 2);
    end
    chk("R5 short glitches ignored", flag, 0);
  endtask

  task automatic t_edges();
    do_reset(2'b01);
    pulse_n(3);
    chk("R6 falling edges not counted", flag, 0);
    evt_raw = 1'b1;
    wait_ticks(40);
    chk("R6 held level is one event", flag, 1);
    evt_raw = 1'b0;
    wait_ticks(DEB + 4);
  endtask

  task automatic t_expire();
    do_reset(2'b01);
    pulse_n(3);
    wait_ticks(WIN + 50);
    pulse_evt();
    chk("R2 count restarted after expiry", flag, 0);
    pulse_n(3);
    chk("R2 four in fresh window", flag, 1);
  endtask

  task automatic t_stopped();
    do_reset(2'b00);
    run_en = 1'b0;
    pulse_n(3);
    chk("R7 no event while stopped", flag, 0);
    run_en = 1'b1;
    do_reset(2'b01);
    pulse_n(2);
    run_en = 1'b0;
    wait_ticks(WIN + 800);
    run_en = 1'b1;
    pulse_evt();
    chk("R7 third event, frozen window", flag, 0);
    pulse_evt();
    chk("R7 window held while stopped", flag, 1);
  endtask

  task automatic t_thr_change();
    do_reset(2'b01);
    pulse_n(3);
    thresh_sel = 2'b10;
    wait_ticks(2);
    thresh_sel = 2'b01;
    wait_ticks(2);
    pulse_evt();
    chk("R8 count cleared by code change", flag, 0);
    pulse_n(3);
    chk("R8 four after change", flag, 1);
  endtask

  initial begin
    t_reset();
    t_first_event();
    t_thresholds();
    t_sticky_clear();
    t_clr_collide();
    t_glitch();
    t_edges();
    t_thr_change();
    t_expire();
    t_stopped();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule